// File: doc/BRIEF.md
# Precise Exception Retirement Buffer

This block is the in-order retirement buffer of a small out-of-order core. Instructions take a slot in program order and may report completion in any order. Retirement always happens at the oldest slot, one slot per cycle. Because of this, the core only ever acts on an exception or trap at the point where the faulting instruction is the oldest one still in flight.

A slot records two things: whether it has completed, and an event kind with an eight-bit payload. An execution fault does no more than set the kind and payload of its slot. A software interrupt or an undecodable opcode is marked complete as soon as it is allocated, because neither needs an execution unit; a software interrupt keeps its vector in the payload.

When the oldest slot holds an event, the buffer does four things in one cycle:
- it discards every slot;
- it pulses a redirect;
- it presents an assist address built from the event kind and the current 2-bit operating mode;
- it retires nothing in that cycle.

A branch mispredict on slot k cuts the buffer back so that k becomes the youngest slot. The slots older than k, and k itself, are kept.

Top module: `precise_rob`

## Requirements
- R1: After reset the buffer is empty: occupancy is 0, alloc_ready is 1, and neither retire_valid nor redirect_valid is asserted.
- R2: Allocations receive tags 0,1,2,... in order, modulo DEPTH (16). With 16 live slots alloc_ready is 0, and an allocation request does not change occupancy.
- R3: A normal slot retires only after it has completed. Retirement takes the oldest slot, one per cycle, in tag order, whatever the order of completion.
- R4: A fault reported with done_fault=1 only marks its slot. No redirect occurs until that slot is the oldest, and younger slots that have completed do not retire.
- R5: When the oldest slot carries an event, redirect_valid is high for exactly one cycle and retire_valid is low in that cycle. Every slot is discarded, so occupancy is 0 in the following cycle. The next allocation receives the tag of the event slot.
- R6: With redirect_valid high, assist_addr equals {ASSIST_BASE[15:4], kind, mode}. The kind codes are 01 for an execution fault, 10 for an invalid opcode and 11 for a software interrupt. event_info holds the fault code or the stored payload.
- R7: alloc_op=11 allocates a software interrupt. It is complete at allocation, needs no done report, and raises an event whose event_info is the vector given in alloc_info.
- R8: alloc_op=10 allocates an invalid-opcode slot, which is complete at allocation. When several of these are allocated back to back, only the oldest raises a redirect; the others are discarded. alloc_op=00 (and 01) allocates a normal slot.
- R9: A mispredict on tag k leaves k as the youngest slot. Occupancy becomes k-head+1, the next allocation receives tag k+1, and the slots up to k still retire normally.
- R10: A mispredict on a slot older than an event slot squashes that event, so no redirect is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_op | input | 2 | Slot type: 00 normal, 10 invalid opcode, 11 software interrupt |
| alloc_info | input | 8 | Payload stored with the slot (interrupt vector) |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_tag | output | 4 | Tag given to the allocated slot |
| done_valid | input | 1 | Completion report |
| done_tag | input | 4 | Tag of the completing slot |
| done_fault | input | 1 | Completion carries an execution fault |
| done_code | input | 8 | Fault code recorded with the fault |
| mp_valid | input | 1 | Branch mispredict report |
| mp_tag | input | 4 | Tag of the mispredicted branch |
| mode | input | 2 | Current operating mode |
| retire_valid | output | 1 | Oldest slot retires this cycle |
| retire_tag | output | 4 | Tag of the retiring slot |
| redirect_valid | output | 1 | Event taken at the oldest slot, fetch redirect |
| assist_addr | output | 16 | Assist routine address for the event |
| event_info | output | 8 | Fault code or vector of the event |
| occupancy | output | 5 | Number of live slots |

## Verification
The assertions assume the following about the inputs:
- done_tag names a live slot that has not completed yet;
- mp_tag names a live slot;
- a mispredict is never reported in a cycle in which a redirect is raised.

Under these assumptions, occupancy changes only through allocation, retirement, mispredict and flush. The stimulus keeps within them because the bench tracks tags itself from the allocation order, and it reports completions and mispredicts only for tags it has allocated since the last flush. Every sequence then waits until the buffer has drained before the next one starts.

// File: rtl/precise_rob.sv
module precise_rob #(
  parameter int DEPTH = 16,
  parameter int INFO_W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] ASSIST_BASE = 16'h8000,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_op,
  input  logic [INFO_W-1:0] alloc_info,
  output logic              alloc_ready,
  output logic [IW-1:0]     alloc_tag,
  input  logic              done_valid,
  input  logic [IW-1:0]     done_tag,
  input  logic              done_fault,
  input  logic [INFO_W-1:0] done_code,
  input  logic              mp_valid,
  input  logic [IW-1:0]     mp_tag,
  input  logic [1:0]        mode,
  output logic              retire_valid,
  output logic [IW-1:0]     retire_tag,
  output logic              redirect_valid,
  output logic [AW-1:0]     assist_addr,
  output logic [INFO_W-1:0] event_info,
  output logic [IW:0]       occupancy
);
  localparam logic [1:0] K_NONE  = 2'b00;
  localparam logic [1:0] K_FAULT = 2'b01;
  localparam logic [IW:0] ONE = 1;
  localparam logic [IW:0] FULL = DEPTH[IW:0];

  logic [IW-1:0]     head_q, tail_q;
  logic [IW:0]       count_q;
  logic              done_q [DEPTH];
  logic [1:0]        kind_q [DEPTH];
  logic [INFO_W-1:0] info_q [DEPTH];

  logic head_ok, alloc_fire;
  logic [IW-1:0] mp_span;
  logic [IW:0] ret_ext;

  assign head_ok        = (count_q != '0) && done_q[head_q];
  assign retire_valid   = head_ok && (kind_q[head_q] == K_NONE);
  assign redirect_valid = head_ok && (kind_q[head_q] != K_NONE);
  assign retire_tag     = head_q;
  assign assist_addr    = {ASSIST_BASE[AW-1:4], kind_q[head_q], mode};
  assign event_info     = info_q[head_q];
  assign occupancy      = count_q;
  assign alloc_ready    = (count_q != FULL) && !redirect_valid && !mp_valid;
  assign alloc_fire     = alloc_valid && alloc_ready;
  assign alloc_tag      = tail_q;
  assign mp_span        = mp_tag - head_q;
  assign ret_ext        = {{IW{1'b0}}, retire_valid};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (redirect_valid) begin
      tail_q  <= head_q;
      count_q <= '0;
    end else begin
      head_q <= head_q + {{(IW-1){1'b0}}, retire_valid};
      if (mp_valid) begin
        tail_q  <= mp_tag + 1'b1;
        count_q <= {1'b0, mp_span} + ONE - ret_ext;
      end else begin
        tail_q  <= tail_q + {{(IW-1){1'b0}}, alloc_fire};
        count_q <= count_q + {{IW{1'b0}}, alloc_fire} - ret_ext;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        done_q[i] <= 1'b0;
        kind_q[i] <= K_NONE;
        info_q[i] <= '0;
      end else if (alloc_fire && tail_q == IW'(i)) begin
        done_q[i] <= alloc_op[1];
        kind_q[i] <= alloc_op[1] ? alloc_op : K_NONE;
        info_q[i] <= alloc_info;
      end else if (done_valid && done_tag == IW'(i)) begin
        done_q[i] <= 1'b1;
        if (done_fault) begin
          kind_q[i] <= K_FAULT;
          info_q[i] <= done_code;
        end
      end
    end
  end
endmodule

// File: rtl/precise_rob_chk.sv
module precise_rob_chk #(
  parameter int DEPTH = 16,
  parameter int AW = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [1:0]    mode,
  input logic          retire_valid,
  input logic [IW-1:0] retire_tag,
  input logic          redirect_valid,
  input logic [AW-1:0] assist_addr,
  input logic [IW:0]   occupancy
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= (IW+1)'(DEPTH)); // R2
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy == (IW+1)'(DEPTH) |-> !alloc_ready); // R2
  AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready && !retire_valid |=> occupancy == $past(occupancy) + 1'b1); // R2
  AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> !retire_valid || retire_tag == $past(retire_tag) + 1'b1); // R3
  AST_NO_RETIRE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !retire_valid); // R5
  AST_EVENT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> occupancy == '0 && !redirect_valid); // R5
  AST_ASSIST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> assist_addr[1:0] == mode && assist_addr[3:2] != 2'b00); // R6
endmodule

bind precise_rob precise_rob_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .mode(mode), .retire_valid(retire_valid), .retire_tag(retire_tag),
  .redirect_valid(redirect_valid), .assist_addr(assist_addr), .occupancy(occupancy)
);

// File: tb/precise_rob_tb_top.sv
module precise_rob_tb_top;
  localparam logic [15:0] BASE = 16'h8000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, done_valid = 0, done_fault = 0, mp_valid = 0;
  logic [1:0] alloc_op = 0, mode = 0;
  logic [7:0] alloc_info = 0, done_code = 0;
  logic [3:0] done_tag = 0, mp_tag = 0;
  logic alloc_ready, retire_valid, redirect_valid;
  logic [3:0] alloc_tag, retire_tag;
  logic [15:0] assist_addr;
  logic [7:0] event_info;
  logic [4:0] occupancy;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int ret_log[$];
  logic [23:0] rd_log[$];

  always #4 clk = ~clk;

  precise_rob dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_op(alloc_op),
    .alloc_info(alloc_info), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .done_valid(done_valid), .done_tag(done_tag), .done_fault(done_fault),
    .done_code(done_code), .mp_valid(mp_valid), .mp_tag(mp_tag), .mode(mode),
    .retire_valid(retire_valid), .retire_tag(retire_tag),
    .redirect_valid(redirect_valid), .assist_addr(assist_addr),
    .event_info(event_info), .occupancy(occupancy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (retire_valid) ret_log.push_back(int'(retire_tag));
    if (redirect_valid) begin
      rd_log.push_back({event_info, assist_addr});
      chk("R5", "retire during redirect", int'(retire_valid), 0);
    end
  end

  task automatic do_alloc(input logic [1:0] op, input logic [7:0] info, output int tag);
    alloc_valid = 1; alloc_op = op; alloc_info = info;
    @(negedge clk);
    tag = int'(alloc_tag);
    chk("R2", "alloc_ready", int'(alloc_ready), 1);
    @(posedge clk); #1;
    alloc_valid = 0;
  endtask

  task automatic do_done(input int tag, input logic f, input logic [7:0] code);
    done_valid = 1; done_tag = tag[3:0]; done_fault = f; done_code = code;
    @(posedge clk); #1;
    done_valid = 0; done_fault = 0;
  endtask

  task automatic do_mp(input int tag);
    mp_valid = 1; mp_tag = tag[3:0];
    @(posedge clk); #1;
    mp_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_ret(input string req, input int n, input int first);
    chk(req, "retire count", ret_log.size(), n);
    if (ret_log.size() == n)
      for (int i = 0; i < n; i++) chk(req, "retire tag", ret_log[i], (first + i) & 15);
    ret_log.delete();
  endtask

  task automatic check_rd(input string req, input int n, input logic [23:0] exp);
    chk(req, "redirect count", rd_log.size(), n);
    if (n == 1 && rd_log.size() == 1) chk(req, "redirect info/addr", int'(rd_log[0]), int'(exp));
    rd_log.delete();
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, t3, nxt;
    int a[6];
    logic [7:0] vecs[4];
    vecs[0] = 8'h00; vecs[1] = 8'h21; vecs[2] = 8'h80; vecs[3] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "occupancy", int'(occupancy), 0);
    chk("R1", "alloc_ready", int'(alloc_ready), 1);
    chk("R1", "retire_valid", int'(retire_valid), 0);
    chk("R1", "redirect_valid", int'(redirect_valid), 0);
    @(posedge clk); #1;

    // R2 fill in order
    for (int i = 0; i < 16; i++) begin
      do_alloc(2'b00, 8'h0, t0);
      chk("R2", "alloc tag", t0, i);
    end
    alloc_valid = 1;
    @(negedge clk);
    chk("R2", "ready when full", int'(alloc_ready), 0);
    @(posedge clk); #1;
    alloc_valid = 0;
    @(negedge clk);
    chk("R2", "occupancy when full", int'(occupancy), 16);
    @(posedge clk); #1;

    // R3 reverse completion, in-order retirement
    for (int i = 15; i >= 1; i--) do_done(i, 1'b0, 8'h0);
    chk("R3", "no retire before head done", ret_log.size(), 0);
    do_done(0, 1'b0, 8'h0);
    idle(18);
    check_ret("R3", 16, 0);
    chk("R3", "drained", int'(occupancy), 0);
    nxt = 0;

    // R4 R6 execution fault over all modes
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      do_alloc(2'b00, 8'h0, t0);
      chk("R5", "tag after flush", t0, nxt);
      do_alloc(2'b00, 8'h0, t1);
      do_alloc(2'b00, 8'h0, t2);
      do_alloc(2'b00, 8'h0, t3);
      do_done(t2, 1'b1, 8'h50 + 8'(m));
      idle(2);
      chk("R4", "no early redirect", rd_log.size(), 0);
      do_done(t3, 1'b0, 8'h0);
      do_done(t0, 1'b0, 8'h0);
      do_done(t1, 1'b0, 8'h0);
      idle(4);
      check_ret("R4", 2, t0);
      check_rd("R6", 1, {8'h50 + 8'(m), BASE | 16'(4 * 1 + m)});
      chk("R5", "flushed", int'(occupancy), 0);
      nxt = t2;
    end

    // R7 R6 software interrupt sweep over modes and vectors
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 4; v++) begin
        mode = m[1:0];
        do_alloc(2'b00, 8'h0, t0);
        chk("R5", "tag after flush", t0, nxt);
        do_alloc(2'b11, vecs[v], t1);
        do_alloc(2'b00, 8'h0, t2);
        do_done(t2, 1'b0, 8'h0);
        idle(2);
        chk("R7", "waits for older slot", rd_log.size(), 0);
        do_done(t0, 1'b0, 8'h0);
        idle(4);
        check_ret("R7", 1, t0);
        check_rd("R7", 1, {vecs[v], BASE | 16'(4 * 3 + m)});
        chk("R5", "flushed", int'(occupancy), 0);
        nxt = t1;
      end
    end

    // R8 back-to-back invalid opcodes
    mode = 2'b01;
    do_alloc(2'b00, 8'h0, t0);
    do_alloc(2'b10, 8'h11, t1);
    do_alloc(2'b10, 8'h22, t2);
    do_alloc(2'b10, 8'h33, t3);
    do_done(t0, 1'b0, 8'h0);
    idle(6);
    check_ret("R8", 1, t0);
    check_rd("R8", 1, {8'h11, BASE | 16'(4 * 2 + 1)});
    chk("R8", "flushed", int'(occupancy), 0);

    // R9 mispredict cut-back
    for (int i = 0; i < 6; i++) do_alloc(2'b00, 8'h0, a[i]);
    do_done(a[4], 1'b0, 8'h0);
    do_mp(a[2]);
    @(negedge clk);
    chk("R9", "occupancy after mispredict", int'(occupancy), 3);
    @(posedge clk); #1;
    do_alloc(2'b00, 8'h0, t3);
    chk("R9", "tag after mispredict", t3, (a[2] + 1) & 15);
    for (int i = 0; i < 3; i++) do_done(a[i], 1'b0, 8'h0);
    idle(2);
    chk("R9", "re-allocated slot waits", int'(occupancy), 1);
    do_done(t3, 1'b0, 8'h0);
    idle(4);
    check_ret("R9", 4, a[0]);
    check_rd("R9", 0, 24'h0);
    chk("R9", "drained", int'(occupancy), 0);

    // R10 mispredict squashes younger trap
    do_alloc(2'b00, 8'h0, t0);
    do_alloc(2'b11, 8'h42, t1);
    do_alloc(2'b00, 8'h0, t2);
    do_mp(t0);
    do_done(t0, 1'b0, 8'h0);
    idle(4);
    check_ret("R10", 1, t0);
    check_rd("R10", 0, 24'h0);
    chk("R10", "drained", int'(occupancy), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule